// File: doc/BRIEF.md
# Video Line Test Pattern Generator

The generator emits one synthetic composite-video line as a stream of signed 10-bit samples, one sample per enabled clock, for driving a video filter under test. Each line is 1716 samples long and contains, in this sequence, a front blanking stretch, a sync pulse with raised-cosine edges, a short gap, a colour burst, a back porch, an active-video luminance ramp carrying a chroma sine, and a linear decay tail. The line then repeats. Levels are expressed in IRE, with 1 IRE = 1/140 V. The sample code is the voltage times 512, rounded, so the format has 9 fractional bits.

A state machine walks the line segments by sample index. The states and their transitions are: `ST_FRONT` (samples 1–32) to `ST_FALL` (33–40) to `ST_LOW` (41–170) to `ST_RISE` (171–178) to `ST_GAP` (179) to `ST_BURST` (180–247) to `ST_PORCH` (248–259) to `ST_ACTIVE` (260–1675) to `ST_TAIL` (1676–1716), and from there back to `ST_FRONT`. A state is left on the last sample index of its segment. A subcarrier phase accumulator advances 35/264 of a cycle per sample, which is the 3.579545 MHz to 27 MHz ratio. It reads a quarter-wave sine table that is computed at elaboration. Two remainder accumulators produce the ramp and the tail without a divider. Dropping the enable input freezes the whole sequence in place.

Top module: `vtpg_line_gen`

## Requirements
- R1: While reset is asserted and after it is released, before the first enabled clock, `sample` is 0 and `sol` and `vld` are 0.
- R2: Each enabled clock emits the next sample index, starting at 1 after reset and wrapping from 1716 to 1. `sol` is 1 exactly on the output cycle that carries sample 1, and 0 on every other cycle.
- R3: Samples 1–32, 179 and 248–259 are 0.
- R4: Samples 33–40 follow the falling edge `round(-146.2857 * sin^2(pi*j/16))` with j = index-33, giving codes 0, -6, -21, -45, -73, -101, -125, -141.
- R5: Samples 41–170 hold the sync tip of -40 IRE, which is code -146.
- R6: Samples 171–178 are the falling-edge codes in reverse order, from -141 back to 0.
- R7: Samples 180–247 carry a 20 IRE sine, where sample 180+k has phase 35k/264 of a cycle. Each code is within 2 of the rounded ideal value.
- R8: Samples 260–1675 carry 7.5 + 72.5·a/1416 IRE plus 20·sin(2π·35a/264) IRE, with a = index-259. Each code is within 2 of the rounded ideal value.
- R9: Samples 1676–1716 carry 72.5·(41-i)/41 IRE, with i = index-1676. Each code is within 2 of the rounded ideal value.
- R10: A clock with `en` low emits nothing. On the following output cycle `vld` is 0, `sol` is 0 and `sample` keeps its previous value. The next enabled clock continues with the index that would have come next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance enable; low pauses the line in place |
| sample | output | 10 | Signed sample code, volts times 512 |
| sol | output | 1 | Start-of-line marker, high with sample 1 |
| vld | output | 1 | High when `sample` was produced on the last clock |

## Verification
The risky coincidences are a pause landing on the clock where the machine changes state and reloads an accumulator, and a pause landing on the line wrap where `sol` must appear. The bench holds `en` low for two clocks right before samples 1, 33, 41, 171, 180, 260, 1676 and 1716. It then runs a line in which every third clock is idle. A scoreboard checks that every resumed sample matches the ideal value of the next index, that the held sample does not move while paused, and that `sol` appears only with sample 1.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;

    localparam int unsigned SMP_W    = 10;
    localparam int unsigned POS_W    = 11;
    localparam int unsigned AMP_W    = 8;
    localparam int unsigned LINE_LEN = 1716;

    // first sample index of each segment
    localparam int unsigned FALL_FIRST  = 33;
    localparam int unsigned LOW_FIRST   = 41;
    localparam int unsigned RISE_FIRST  = 171;
    localparam int unsigned GAP_IDX     = 179;
    localparam int unsigned BURST_FIRST = 180;
    localparam int unsigned PORCH_FIRST = 248;
    localparam int unsigned ACT_FIRST   = 260;
    localparam int unsigned TAIL_FIRST  = 1676;
    localparam int unsigned EDGE_LEN    = 8;

    // -40 IRE as a code: 40/140*512 rounded
    localparam int unsigned SYNC_TIP = 146;

    // ramp code = (RAMP_BASE + RAMP_STEP*a) / RAMP_DIV, a = 1..1416
    localparam int unsigned RAMP_DIV   = 1239;
    localparam int unsigned RAMP_STEP  = 232;
    localparam int unsigned RAMP_BASE  = 33984;
    localparam int unsigned RAMP_INT0  = (RAMP_BASE + RAMP_STEP) / RAMP_DIV;
    localparam int unsigned RAMP_REM0  = (RAMP_BASE + RAMP_STEP) % RAMP_DIV;

    // tail code = TAIL_UNIT*(TAIL_STEPS-i) / TAIL_DIV
    localparam int unsigned TAIL_DIV   = 287;
    localparam int unsigned TAIL_UNIT  = 1856;
    localparam int unsigned TAIL_STEPS = 41;
    localparam int unsigned TAIL_INT0  = (TAIL_UNIT * TAIL_STEPS) / TAIL_DIV;
    localparam int unsigned TAIL_REM0  = (TAIL_UNIT * TAIL_STEPS) % TAIL_DIV;
    localparam int unsigned TAIL_DINT  = TAIL_UNIT / TAIL_DIV;
    localparam int unsigned TAIL_DREM  = TAIL_UNIT % TAIL_DIV;

    typedef enum logic [3:0] {
        ST_FRONT, ST_FALL, ST_LOW, ST_RISE, ST_GAP,
        ST_BURST, ST_PORCH, ST_ACTIVE, ST_TAIL
    } seg_e;

endpackage

// File: rtl/vtpg_timing.sv
module vtpg_timing
    import vtpg_pkg::*;
#(
    parameter int unsigned PW   = POS_W,
    parameter int unsigned LLEN = LINE_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [PW-1:0] pos,
    output seg_e          state,
    output seg_e          state_nxt
);

    function automatic logic at_idx(input logic [PW-1:0] p, input int unsigned idx);
        return p == PW'(idx);
    endfunction

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FRONT:  if (at_idx(pos, FALL_FIRST - 1))  state_nxt = ST_FALL;
            ST_FALL:   if (at_idx(pos, LOW_FIRST - 1))   state_nxt = ST_LOW;
            ST_LOW:    if (at_idx(pos, RISE_FIRST - 1))  state_nxt = ST_RISE;
            ST_RISE:   if (at_idx(pos, GAP_IDX - 1))     state_nxt = ST_GAP;
            ST_GAP:    if (at_idx(pos, BURST_FIRST - 1)) state_nxt = ST_BURST;
            ST_BURST:  if (at_idx(pos, PORCH_FIRST - 1)) state_nxt = ST_PORCH;
            ST_PORCH:  if (at_idx(pos, ACT_FIRST - 1))   state_nxt = ST_ACTIVE;
            ST_ACTIVE: if (at_idx(pos, TAIL_FIRST - 1))  state_nxt = ST_TAIL;
            ST_TAIL:   if (at_idx(pos, LLEN))            state_nxt = ST_FRONT;
            default:                                     state_nxt = ST_FRONT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos   <= PW'(1);
            state <= ST_FRONT;
        end else if (en) begin
            state <= state_nxt;
            pos   <= at_idx(pos, LLEN) ? PW'(1) : pos + PW'(1);
        end
    end

endmodule

// File: rtl/vtpg_chroma.sv
module vtpg_chroma
    import vtpg_pkg::*;
#(
    parameter int unsigned PH_MOD = 264,
    parameter int unsigned PH_INC = 35,
    parameter int unsigned AW     = AMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ld_burst,
    input  logic              ld_active,
    output logic signed [AW:0] chroma
);

    localparam int unsigned PHW = $clog2(PH_MOD);
    localparam int unsigned QTR = PH_MOD / 4;
    localparam longint ONE_Q30    = 64'sd1073741824;
    localparam longint TWO_PI_Q30 = 64'sd6746518852;
    localparam longint AMP_NUM    = 64'sd512;   // 20 IRE = 512/7 codes
    localparam longint AMP_DEN    = 64'sd7;

    // quarter-wave table from a Chebyshev recurrence in Q30
    function automatic logic [(QTR+1)*AW-1:0] build_qtab();
        logic [(QTR+1)*AW-1:0] tab;
        longint th, th2, th3, th4, th5, s1, c2, sp, sc, sn, v;
        th  = TWO_PI_Q30 / longint'(PH_MOD);
        th2 = (th * th) >>> 30;
        th3 = (th2 * th) >>> 30;
        th4 = (th3 * th) >>> 30;
        th5 = (th4 * th) >>> 30;
        s1  = th - th3 / 6 + th5 / 120;
        c2  = 2 * (ONE_Q30 - th2 / 2 + th4 / 24);
        tab = '0;
        sp  = 0;
        sc  = s1;
        for (int n = 1; n <= int'(QTR); n++) begin
            v  = (sc * AMP_NUM + (AMP_DEN <<< 29)) / (AMP_DEN <<< 30);
            tab[n*AW +: AW] = AW'(v);
            sn = ((c2 * sc) >>> 30) - sp;
            sp = sc;
            sc = sn;
        end
        return tab;
    endfunction

    localparam logic [(QTR+1)*AW-1:0] QTAB = build_qtab();

    logic [PHW-1:0] ph, ph_step, rem, idx;
    logic           neg, mir;
    logic [AW-1:0]  mag;

    always_comb begin
        ph_step = (ph >= PHW'(PH_MOD - PH_INC)) ? ph - PHW'(PH_MOD - PH_INC)
                                                : ph + PHW'(PH_INC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         ph <= '0;
        else if (en) begin
            if (ld_burst)       ph <= '0;
            else if (ld_active) ph <= PHW'(PH_INC);
            else                ph <= ph_step;
        end
    end

    always_comb begin
        if (ph < PHW'(QTR)) begin
            neg = 1'b0; mir = 1'b0; rem = ph;
        end else if (ph < PHW'(2*QTR)) begin
            neg = 1'b0; mir = 1'b1; rem = ph - PHW'(QTR);
        end else if (ph < PHW'(3*QTR)) begin
            neg = 1'b1; mir = 1'b0; rem = ph - PHW'(2*QTR);
        end else begin
            neg = 1'b1; mir = 1'b1; rem = ph - PHW'(3*QTR);
        end
        idx    = mir ? PHW'(QTR) - rem : rem;
        mag    = QTAB[idx*AW +: AW];
        chroma = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

endmodule

// File: rtl/vtpg_ramp.sv
module vtpg_ramp
    import vtpg_pkg::*;
#(
    parameter int unsigned SW = SMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ld_ramp,
    input  logic          run_ramp,
    input  logic          ld_tail,
    input  logic          run_tail,
    output logic [SW-1:0] ramp_q,
    output logic [SW-1:0] tail_q
);

    localparam int unsigned RW = $clog2(RAMP_DIV) + 1;
    localparam int unsigned TW = $clog2(TAIL_DIV) + 1;

    logic [SW-1:0] r_int, t_int;
    logic [RW-1:0] r_rem, r_sum;
    logic [TW-1:0] t_rem;

    assign r_sum = r_rem + RW'(RAMP_STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_int <= '0; r_rem <= '0;
            t_int <= '0; t_rem <= '0;
        end else if (en) begin
            if (ld_ramp) begin
                r_int <= SW'(RAMP_INT0);
                r_rem <= RW'(RAMP_REM0);
            end else if (run_ramp) begin
                if (r_sum >= RW'(RAMP_DIV)) begin
                    r_int <= r_int + SW'(1);
                    r_rem <= r_sum - RW'(RAMP_DIV);
                end else begin
                    r_rem <= r_sum;
                end
            end
            if (ld_tail) begin
                t_int <= SW'(TAIL_INT0);
                t_rem <= TW'(TAIL_REM0);
            end else if (run_tail) begin
                if (t_rem >= TW'(TAIL_DREM)) begin
                    t_int <= t_int - SW'(TAIL_DINT);
                    t_rem <= t_rem - TW'(TAIL_DREM);
                end else begin
                    t_int <= t_int - SW'(TAIL_DINT + 1);
                    t_rem <= t_rem + TW'(TAIL_DIV - TAIL_DREM);
                end
            end
        end
    end

    // round to nearest: add one when the remainder reaches half the divisor
    assign ramp_q = r_int + SW'({r_rem, 1'b0} >= (RW+1)'(RAMP_DIV));
    assign tail_q = t_int + SW'({t_rem, 1'b0} >= (TW+1)'(TAIL_DIV));

endmodule

// File: rtl/vtpg_line_gen.sv
module vtpg_line_gen
    import vtpg_pkg::*;
#(
    parameter int unsigned PH_MOD = 264,
    parameter int unsigned PH_INC = 35
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    output logic signed [SMP_W-1:0] sample,
    output logic                    sol,
    output logic                    vld
);

    logic [POS_W-1:0]         pos;
    seg_e                     state, state_nxt;
    logic signed [AMP_W:0]    chroma;
    logic [SMP_W-1:0]         ramp_q, tail_q;
    logic [SMP_W-1:0]         level;
    logic [2:0]               fall_j, rise_j;
    logic                     ld_burst, ld_active, ld_tail;

    assign ld_burst  = (state != ST_BURST)  && (state_nxt == ST_BURST);
    assign ld_active = (state != ST_ACTIVE) && (state_nxt == ST_ACTIVE);
    assign ld_tail   = (state != ST_TAIL)   && (state_nxt == ST_TAIL);

    vtpg_timing u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .pos       (pos),
        .state     (state),
        .state_nxt (state_nxt)
    );

    vtpg_chroma #(.PH_MOD(PH_MOD), .PH_INC(PH_INC)) u_chroma (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ld_burst  (ld_burst),
        .ld_active (ld_active),
        .chroma    (chroma)
    );

    vtpg_ramp u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ld_ramp  (ld_active),
        .run_ramp (state == ST_ACTIVE),
        .ld_tail  (ld_tail),
        .run_tail (state == ST_TAIL),
        .ramp_q   (ramp_q),
        .tail_q   (tail_q)
    );

    // depth of the raised-cosine sync edge, step j of EDGE_LEN
    function automatic logic [SMP_W-1:0] edge_mag(input logic [2:0] j);
        unique case (j)
            3'd0:    return SMP_W'(0);
            3'd1:    return SMP_W'(6);
            3'd2:    return SMP_W'(21);
            3'd3:    return SMP_W'(45);
            3'd4:    return SMP_W'(73);
            3'd5:    return SMP_W'(101);
            3'd6:    return SMP_W'(125);
            3'd7:    return SMP_W'(141);
            default: return SMP_W'(0);
        endcase
    endfunction

    always_comb begin
        fall_j = 3'(pos - POS_W'(FALL_FIRST));
        rise_j = 3'(POS_W'(RISE_FIRST + EDGE_LEN - 1) - pos);
        unique case (state)
            ST_FRONT, ST_GAP, ST_PORCH: level = '0;
            ST_FALL:   level = SMP_W'(0) - edge_mag(fall_j);
            ST_LOW:    level = SMP_W'(0) - SMP_W'(SYNC_TIP);
            ST_RISE:   level = SMP_W'(0) - edge_mag(rise_j);
            ST_BURST:  level = SMP_W'(chroma);
            ST_ACTIVE: level = ramp_q + SMP_W'(chroma);
            ST_TAIL:   level = tail_q;
            default:   level = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
            sol    <= 1'b0;
            vld    <= 1'b0;
        end else begin
            vld <= en;
            sol <= en && (pos == POS_W'(1));
            if (en) sample <= $signed(level);
        end
    end

endmodule

// File: rtl/vtpg_line_gen_chk.sv
module vtpg_line_gen_chk
    import vtpg_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic signed [SMP_W-1:0] sample,
    input logic                    sol,
    input logic                    vld,
    input logic [POS_W-1:0]        pos,
    input seg_e                    state
);

    AST_VLD_TRACKS_EN: assert property (@(posedge clk) disable iff (!rst_n) en |=> vld); // R10
    AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !vld && !sol); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(sample)); // R10
    AST_SOL_IS_BLANK: assert property (@(posedge clk) disable iff (!rst_n) sol |-> vld && sample == '0); // R3
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n) en && pos == POS_W'(LINE_LEN) |=> pos == POS_W'(1)); // R2
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) pos >= POS_W'(1) && pos <= POS_W'(LINE_LEN)); // R2
    AST_SYNC_TIP: assert property (@(posedge clk) disable iff (!rst_n) en && state == ST_LOW |=> sample == -$signed(SMP_W'(SYNC_TIP))); // R5
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) en && (state == ST_GAP || state == ST_PORCH) |=> sample == '0); // R3

endmodule

bind vtpg_line_gen vtpg_line_gen_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .sample (sample),
    .sol    (sol),
    .vld    (vld),
    .pos    (pos),
    .state  (state)
);

// File: tb/vtpg_line_gen_tb.sv
module vtpg_line_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LINE       = 1716;
    localparam real PI        = 3.14159265358979;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic signed [9:0] sample;
    logic              sol;
    logic              vld;

    int n_cmp  = 0;
    int n_fail = 0;
    int exp_q[$];
    int nxt    = 1;
    logic signed [9:0] last_smp = '0;
    bit   seen_any = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vtpg_line_gen u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .sample (sample),
        .sol    (sol),
        .vld    (vld)
    );

    function automatic real ideal_ire(input int n);
        real fr, c;
        fr = (5.0e6 * 63.0 / 88.0) / 27.0e6;
        if (n >= 33 && n <= 40) begin
            c = $cos(PI / 2.0 * real'(n - 33) / 8.0);
            return (c * c - 1.0) * 40.0;
        end
        if (n >= 41 && n <= 170) return -40.0;
        if (n >= 171 && n <= 178) begin
            c = $cos(PI / 2.0 * real'(178 - n) / 8.0);
            return (c * c - 1.0) * 40.0;
        end
        if (n >= 180 && n <= 247) return 20.0 * $sin(2.0 * PI * fr * real'(n - 180));
        if (n >= 260 && n <= 1675)
            return 7.5 + 72.5 * real'(n - 259) / 1416.0 + 20.0 * $sin(2.0 * PI * fr * real'(n - 259));
        if (n >= 1676 && n <= 1716) return 72.5 * real'(41 - (n - 1676)) / 41.0;
        return 0.0;
    endfunction

    function automatic int ideal_code(input int n);
        return $rtoi($floor(ideal_ire(n) / 140.0 * 512.0 + 0.5));
    endfunction

    function automatic string req_of(input int n);
        if (n >= 33 && n <= 40)     return "R4";
        if (n >= 41 && n <= 170)    return "R5";
        if (n >= 171 && n <= 178)   return "R6";
        if (n >= 180 && n <= 247)   return "R7";
        if (n >= 260 && n <= 1675)  return "R8";
        if (n >= 1676)              return "R9";
        return "R3";
    endfunction

    function automatic int tol_of(input int n);
        return (n >= 180 && n <= 247) || n >= 260 ? 2 : 0;
    endfunction

    task automatic step(input bit e);
        @(negedge clk);
        en = e;
        if (e) begin
            exp_q.push_back(nxt);
            nxt = (nxt == LINE) ? 1 : nxt + 1;
        end
    endtask

    // monitor: pop the expected index for each produced sample
    initial begin : monitor
        int idx, ex, diff;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst_n) begin
                if (vld) begin
                    n_cmp++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R2 unexpected sample: actual %0d expected none", sample);
                    end else begin
                        idx  = exp_q.pop_front();
                        ex   = ideal_code(idx);
                        diff = int'(sample) - ex;
                        if (diff > tol_of(idx) || -diff > tol_of(idx)) begin
                            n_fail++;
                            $display("FAIL %s index %0d: actual %0d expected %0d", req_of(idx), idx, sample, ex);
                        end
                        n_cmp++;
                        if (sol !== (idx == 1)) begin
                            n_fail++;
                            $display("FAIL R2 sol at index %0d: actual %0b expected %0b", idx, sol, idx == 1);
                        end
                    end
                    last_smp = sample;
                    seen_any = 1'b1;
                end else if (seen_any) begin
                    n_cmp++;
                    if (sample !== last_smp || sol !== 1'b0) begin
                        n_fail++;
                        $display("FAIL R10 paused output: actual %0d/%0b expected %0d/0", sample, sol, last_smp);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin : driver
        repeat (4) @(negedge clk);
        // R1: state held in reset
        n_cmp++;
        if (sample !== 10'sd0 || sol !== 1'b0 || vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 in reset: actual %0d/%0b/%0b expected 0/0/0", sample, sol, vld);
        end
        rst_n = 1'b1;
        repeat (2) step(1'b0);
        #(CLK_PERIOD/4);
        n_cmp++;
        if (sample !== 10'sd0 || sol !== 1'b0 || vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 after release: actual %0d/%0b/%0b expected 0/0/0", sample, sol, vld);
        end
        // line 1: continuous
        for (int k = 0; k < LINE; k++) step(1'b1);
        // line 2: pauses right before segment entries and the wrap (R10, R2)
        for (int k = 0; k < LINE; k++) begin
            if (nxt == 33 || nxt == 41 || nxt == 171 || nxt == 180 ||
                nxt == 260 || nxt == 1676 || nxt == 1716) begin
                step(1'b0);
                step(1'b0);
            end
            step(1'b1);
        end
        // pause on the wrap into line 3
        step(1'b0);
        step(1'b0);
        // line 3: every third clock idle
        for (int k = 0; k < 3 * LINE / 2 + 6; k++) step((k % 3) != 0);
        repeat (4) step(1'b0);
        @(posedge clk);
        #(CLK_PERIOD/2);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing samples: actual %0d left expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule